// File: doc/BRIEF.md
# MIDI Serial Port with Byte FIFOs

This block is a byte-wide, register-mapped serial port for MIDI traffic. The host writes outgoing bytes into a transmit FIFO and reads incoming bytes from a receive FIFO. Each FIFO holds up to 32 bytes. A serializer sends each byte as a 10-bit frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. A deserializer samples the input line at 16 times the bit rate and recovers frames in the same format.

The host accesses the block through a simple synchronous strobe interface. It can read the fill count of each FIFO, so it knows how many bytes it may push or pull in one service pass. A mode bit switches the serial engines on. When the mode bit is clear, the transmitter holds its bytes, the receiver ignores the line and no interrupt condition is raised.

Each FIFO has a programmable watermark. Both watermarks are written through one shared register. A sticky status pair records when a watermark condition has been met, and a mask pair decides which status bits drive the interrupt line.

Top module: `midi_uart_port`

## Requirements
- R1: After reset, the FIFO counts read 0, the control register reads 0x0A, interrupt status reads 0, `irq` is low and `txd` is high.
- R2: A read at 0x0A returns the transmit FIFO fill count. A read at 0x0B returns the receive FIFO fill count.
- R3: A write to the data port at 0x0C pushes one byte into the transmit FIFO. A write while 32 bytes are held is dropped, and the count stays at 32.
- R4: While mode is on, transmit bytes leave in FIFO order. Each byte is sent as a 0 start bit, then data bits LSB first, then a 1 stop bit. Each bit lasts CLK_HZ/BAUD clocks.
- R5: While mode is on, each valid frame on `rxd` is stored in the receive FIFO. A read at 0x0C returns the stored bytes in arrival order, one per read, and removes each one.
- R6: A read of the data port while the receive FIFO is empty returns 0x00 and leaves the receive count unchanged.
- R7: A frame that completes while the receive FIFO holds 32 bytes is discarded.
- R8: The control register at 0x0D holds these bits:
  - bit 0: mode enable, read/write
  - bit 1: transmit FIFO empty
  - bit 2: transmit FIFO full
  - bit 3: receive FIFO empty
  - bit 4: receive FIFO full
  - bits 7:5: read as 0
- R9: A write at 0x0E sets a watermark. If bit 5 of the value is 1, bits 4:0 set the receive watermark; if bit 5 is 0, bits 4:0 set the transmit watermark. After reset the transmit watermark is 0 and the receive watermark is 1.
- R10: Interrupt status at 0x00 has bit 0 for receive and bit 1 for transmit. The receive bit sets while the receive count is at or above the receive watermark. The transmit bit sets while the transmit count is at or below the transmit watermark. A status bit stays set until a 1 is written to it, and it sets again while its condition still holds.
- R11: The mask at 0x01 uses the same bit positions as the status register, and a 1 disables that source. The mask resets to 0x03. `irq` is high while any unmasked status bit is set.
- R12: While mode is off, no status bit becomes set, the receiver ignores `rxd` and the transmitter keeps `txd` high with its bytes held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line, idle high |
| irq | output | 1 | Interrupt request |

## Verification
Read data, FIFO counts and interrupt status are registered. Each of them reflects a strobe or a condition one clock after the edge that captured it, so the bench samples them on the falling edge that follows.

The start bit appears on `txd` one clock after an idle serializer takes a byte. The bench monitor therefore checks each bit half a bit time after the falling edge of the start bit, then once per bit period.

A received byte reaches the FIFO near the middle of its stop bit. The synchronizer and the oversampling phase add a few clocks to that. The bench only reads counts and data after a whole frame has been driven.

// File: rtl/midi_uart_pkg.sv
package midi_uart_pkg;
  localparam logic [3:0] OFS_ISTAT = 4'h0;
  localparam logic [3:0] OFS_IMASK = 4'h1;
  localparam logic [3:0] OFS_TXCNT = 4'hA;
  localparam logic [3:0] OFS_RXCNT = 4'hB;
  localparam logic [3:0] OFS_DATA  = 4'hC;
  localparam logic [3:0] OFS_CTRL  = 4'hD;
  localparam logic [3:0] OFS_WMARK = 4'hE;
  localparam int IRQ_RX      = 0;
  localparam int IRQ_TX      = 1;
  localparam int WM_SEL_BIT  = 5;
  localparam int OS_RATE     = 16;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/midi_byte_fifo.sv
module midi_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [CW-1:0] count_n;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (do_push) wr_ptr_n = wr_ptr + 1'b1;
    if (do_pop)  rd_ptr_n = rd_ptr + 1'b1;
    case ({do_push, do_pop})
      2'b10:   count_n = count + 1'b1;
      2'b01:   count_n = count - 1'b1;
      default: count_n = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  // R3 / R7: a push into a full FIFO leaves the occupancy unchanged
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (count == $past(count)));

  // R6: popping an empty FIFO does not move it
  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/midi_tx_serializer.sv
module midi_tx_serializer #(
  parameter int BIT_DIV = 3200,
  localparam int DW     = $clog2(BIT_DIV)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  output logic       fifo_pop,
  output logic       txd
);
  logic          busy, busy_n;
  logic [DW-1:0] div_cnt, div_cnt_n;
  logic [3:0]    bit_cnt, bit_cnt_n;
  logic [9:0]    shreg, shreg_n;
  logic          txd_n;

  assign fifo_pop = !busy && enable && !fifo_empty;

  always_comb begin
    busy_n    = busy;
    div_cnt_n = div_cnt;
    bit_cnt_n = bit_cnt;
    shreg_n   = shreg;
    if (fifo_pop) begin
      busy_n    = 1'b1;
      shreg_n   = {1'b1, fifo_data, 1'b0};
      div_cnt_n = '0;
      bit_cnt_n = '0;
    end else if (busy) begin
      if (div_cnt == DW'(BIT_DIV - 1)) begin
        div_cnt_n = '0;
        shreg_n   = {1'b1, shreg[9:1]};
        if (bit_cnt == 4'd9) busy_n = 1'b0;
        else                 bit_cnt_n = bit_cnt + 1'b1;
      end else begin
        div_cnt_n = div_cnt + 1'b1;
      end
    end
    txd_n = busy_n ? shreg_n[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      shreg   <= '1;
      txd     <= 1'b1;
    end else begin
      busy    <= busy_n;
      div_cnt <= div_cnt_n;
      bit_cnt <= bit_cnt_n;
      shreg   <= shreg_n;
      txd     <= txd_n;
    end
  end

  // R4: a byte taken from the FIFO starts its frame with a low start bit
  assert_start_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !txd);

  // R4: the last bit slot of a frame is the high stop bit
  assert_stop_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_cnt == 4'd9) |-> txd);
endmodule

// File: rtl/midi_rx_deserializer.sv
module midi_rx_deserializer
  import midi_uart_pkg::*;
#(
  parameter int OS_DIV = 200,
  localparam int OW    = $clog2(OS_DIV)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       rxd,
  output logic       byte_valid,
  output logic [7:0] byte_data
);
  logic          sync1, sync2;
  logic [OW-1:0] os_cnt, os_cnt_n;
  logic          tick;
  rx_state_t     st, st_n;
  logic [3:0]    tc, tc_n;
  logic [2:0]    bi, bi_n;
  logic [7:0]    sh, sh_n;
  logic          vld_n;

  assign tick      = (os_cnt == OW'(OS_DIV - 1));
  assign byte_data = sh;

  always_comb begin
    os_cnt_n = tick ? '0 : os_cnt + 1'b1;
    st_n  = st;
    tc_n  = tc;
    bi_n  = bi;
    sh_n  = sh;
    vld_n = 1'b0;
    if (!enable) begin
      st_n = RX_IDLE;
      tc_n = '0;
    end else if (tick) begin
      case (st)
        RX_IDLE: if (!sync2) begin
          st_n = RX_START;
          tc_n = '0;
        end
        RX_START: if (tc == 4'd7) begin
          tc_n = '0;
          bi_n = '0;
          st_n = sync2 ? RX_IDLE : RX_DATA;
        end else tc_n = tc + 1'b1;
        RX_DATA: if (tc == 4'(OS_RATE - 1)) begin
          tc_n = '0;
          sh_n = {sync2, sh[7:1]};
          if (bi == 3'd7) st_n = RX_STOP;
          else            bi_n = bi + 1'b1;
        end else tc_n = tc + 1'b1;
        default: if (tc == 4'(OS_RATE - 1)) begin
          tc_n  = '0;
          st_n  = RX_IDLE;
          vld_n = sync2;
        end else tc_n = tc + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1      <= 1'b1;
      sync2      <= 1'b1;
      os_cnt     <= '0;
      st         <= RX_IDLE;
      tc         <= '0;
      bi         <= '0;
      sh         <= '0;
      byte_valid <= 1'b0;
    end else begin
      sync1      <= rxd;
      sync2      <= sync1;
      os_cnt     <= os_cnt_n;
      st         <= st_n;
      tc         <= tc_n;
      bi         <= bi_n;
      sh         <= sh_n;
      byte_valid <= vld_n;
    end
  end

  // R5: each recovered frame yields a single-cycle store request
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R12: with the mode off the receiver stays idle
  assert_rx_idle_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st == RX_IDLE || enable));
endmodule

// File: rtl/midi_uart_port.sv
module midi_uart_port
  import midi_uart_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int BAUD   = 31_250,
  parameter int DEPTH  = 32,
  localparam int BIT_DIV = CLK_HZ / BAUD,
  localparam int OS_DIV  = BIT_DIV / OS_RATE,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int WMW     = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  logic           uart_en, uart_en_n;
  logic [WMW-1:0] tx_wm, tx_wm_n, rx_wm, rx_wm_n;
  logic [1:0]     irq_mask, irq_mask_n, irq_stat, irq_stat_n, irq_clr, irq_cond;
  logic [7:0]     rd_nxt;

  logic           tx_push, tx_pop, tx_full, tx_empty;
  logic [7:0]     tx_dout;
  logic [CW-1:0]  tx_count;
  logic           rx_valid, rx_pop, rx_full, rx_empty;
  logic [7:0]     rx_byte, rx_dout;
  logic [CW-1:0]  rx_count;

  assign tx_push = wr_en && (addr == OFS_DATA);
  assign rx_pop  = rd_en && (addr == OFS_DATA);

  midi_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(wdata), .pop(tx_pop),
    .dout(tx_dout), .count(tx_count), .full(tx_full), .empty(tx_empty));

  midi_tx_serializer #(.BIT_DIV(BIT_DIV)) u_tx (
    .clk(clk), .rst_n(rst_n), .enable(uart_en), .fifo_empty(tx_empty),
    .fifo_data(tx_dout), .fifo_pop(tx_pop), .txd(txd));

  midi_rx_deserializer #(.OS_DIV(OS_DIV)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(uart_en), .rxd(rxd),
    .byte_valid(rx_valid), .byte_data(rx_byte));

  midi_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_valid), .din(rx_byte), .pop(rx_pop),
    .dout(rx_dout), .count(rx_count), .full(rx_full), .empty(rx_empty));

  // watermark conditions, only raised in UART mode
  always_comb begin
    irq_cond[IRQ_TX] = uart_en && (tx_count <= {1'b0, tx_wm});
    irq_cond[IRQ_RX] = uart_en && (rx_count >= {1'b0, rx_wm});
  end

  // register writes
  always_comb begin
    uart_en_n  = uart_en;
    tx_wm_n    = tx_wm;
    rx_wm_n    = rx_wm;
    irq_mask_n = irq_mask;
    irq_clr    = '0;
    if (wr_en) begin
      case (addr)
        OFS_CTRL:  uart_en_n  = wdata[0];
        OFS_IMASK: irq_mask_n = wdata[1:0];
        OFS_ISTAT: irq_clr    = wdata[1:0];
        OFS_WMARK: if (wdata[WM_SEL_BIT]) rx_wm_n = wdata[WMW-1:0];
                   else                   tx_wm_n = wdata[WMW-1:0];
        default: ;
      endcase
    end
    irq_stat_n = (irq_stat & ~irq_clr) | irq_cond;
  end

  // read mux
  always_comb begin
    case (addr)
      OFS_ISTAT: rd_nxt = {6'd0, irq_stat};
      OFS_IMASK: rd_nxt = {6'd0, irq_mask};
      OFS_TXCNT: rd_nxt = 8'(tx_count);
      OFS_RXCNT: rd_nxt = 8'(rx_count);
      OFS_DATA:  rd_nxt = rx_empty ? 8'h00 : rx_dout;
      OFS_CTRL:  rd_nxt = {3'd0, rx_full, rx_empty, tx_full, tx_empty, uart_en};
      default:   rd_nxt = 8'h00;
    endcase
  end

  assign irq = |(irq_stat & ~irq_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uart_en  <= 1'b0;
      tx_wm    <= '0;
      rx_wm    <= WMW'(1);
      irq_mask <= 2'b11;
      irq_stat <= 2'b00;
      rdata    <= 8'h00;
    end else begin
      uart_en  <= uart_en_n;
      tx_wm    <= tx_wm_n;
      rx_wm    <= rx_wm_n;
      irq_mask <= irq_mask_n;
      irq_stat <= irq_stat_n;
      if (rd_en) rdata <= rd_nxt;
    end
  end

  // R7: a frame finishing against a full receive FIFO is lost
  assert_rx_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !rx_pop) |=> (rx_full && rx_count == $past(rx_count)));

  // R12: with the mode off, a clear status stays clear
  assert_quiet_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!uart_en && irq_stat == 2'b00) |=> (irq_stat == 2'b00));

  // R12: the transmitter never takes a byte while the mode is off
  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_en |-> !tx_pop);
endmodule

// File: tb/tb_midi_uart_port.sv
module tb_midi_uart_port;
  localparam int CLK_HZ  = 2_000_000;
  localparam int BAUD    = 31_250;
  localparam int BIT     = CLK_HZ / BAUD;

  logic       clk, rst_n, wr_en, rd_en, rxd;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic       txd, irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  midi_uart_port #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEPTH(32)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // driver for the TX side: expected bytes go into the scoreboard queue
  task automatic push_tx(logic [7:0] b, bit expect_sent);
    reg_write(4'hC, b);
    if (expect_sent) tx_q.push_back(b);
  endtask

  task automatic send_serial(logic [7:0] b);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  // monitor: decodes frames on txd and compares with the scoreboard
  initial begin
    logic [7:0] got;
    logic       sb, pb;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge txd);
      repeat (BIT / 2) @(negedge clk);
      sb = txd;
      for (int i = 0; i < 8; i++) begin
        repeat (BIT) @(negedge clk);
        got[i] = txd;
      end
      repeat (BIT) @(negedge clk);
      pb = txd;
      check("R4 start bit", {7'd0, sb}, 8'h00);
      check("R4 stop bit", {7'd0, pb}, 8'h01);
      if (tx_q.size() == 0) check("R4 unexpected frame", got, 8'hxx);
      else                  check("R4 frame byte", got, tx_q.pop_front());
    end
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; rxd = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    reg_read(4'hD, d); check("R1 ctrl", d, 8'h0A);
    reg_read(4'hA, d); check("R1 tx count", d, 8'h00);
    reg_read(4'hB, d); check("R1 rx count", d, 8'h00);
    reg_read(4'h0, d); check("R1 status", d, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 txd", {7'd0, txd}, 8'h01);

    // R3 fill TX with mode off, 33rd write dropped
    for (int i = 0; i < 33; i++) push_tx(8'(8'h40 + i), i < 32);
    reg_read(4'hA, d); check("R3 R2 tx count full", d, 8'd32);
    reg_read(4'hD, d); check("R8 ctrl tx full", d, 8'h0C);

    // R12 mode off: line ignored, no status, txd idle
    reg_write(4'hE, 8'h20);
    send_serial(8'h5A);
    reg_read(4'hB, d); check("R12 rx ignored", d, 8'h00);
    reg_read(4'h0, d); check("R12 no status", d, 8'h00);
    check("R12 txd held", {7'd0, txd}, 8'h01);
    reg_write(4'hE, 8'h21);

    // R6 empty read
    reg_read(4'hC, d); check("R6 empty data", d, 8'h00);
    reg_read(4'hB, d); check("R6 count unchanged", d, 8'h00);

    // enable; TX drains in background, R5 receive path
    reg_write(4'hD, 8'h01);
    reg_read(4'hD, d); check("R8 mode bit", d & 8'h01, 8'h01);
    foreach (rx_q[i]) ;
    rx_q.push_back(8'hA5); send_serial(8'hA5);
    rx_q.push_back(8'h01); send_serial(8'h01);
    rx_q.push_back(8'hF0); send_serial(8'hF0);
    reg_read(4'hB, d); check("R2 R5 rx count", d, 8'd3);
    reg_read(4'h0, d); check("R10 rx status set", d & 8'h01, 8'h01);
    check("R11 irq masked", {7'd0, irq}, 8'h00);
    reg_write(4'h1, 8'h02);
    @(negedge clk);
    check("R11 irq unmasked", {7'd0, irq}, 8'h01);
    for (int i = 0; i < 3; i++) begin
      reg_read(4'hC, d); check("R5 rx data", d, rx_q.pop_front());
    end
    reg_write(4'h0, 8'h01);
    reg_read(4'h0, d); check("R10 rx status cleared", d & 8'h01, 8'h00);
    check("R11 irq low after clear", {7'd0, irq}, 8'h00);
    reg_write(4'h1, 8'h03);

    // wait for TX drain, then TX status
    d = 8'hFF;
    while (d != 8'h00) begin
      repeat (200) @(negedge clk);
      reg_read(4'hA, d);
    end
    reg_read(4'h0, d); check("R10 tx status at wm", d & 8'h02, 8'h02);
    reg_read(4'hD, d); check("R8 tx empty", d & 8'h06, 8'h02);

    // R9 TX watermark = 5
    reg_write(4'hE, 8'h05);
    reg_write(4'hD, 8'h00);
    for (int i = 0; i < 8; i++) push_tx(8'(8'h90 + i), 1'b1);
    reg_write(4'h0, 8'h03);
    reg_read(4'h0, d); check("R12 R10 status clear with mode off", d, 8'h00);
    reg_write(4'hD, 8'h01);
    repeat (20) @(negedge clk);
    reg_write(4'h0, 8'h02);
    reg_read(4'h0, d); check("R9 tx above wm", d & 8'h02, 8'h00);
    d = 8'hFF;
    while (d > 8'd5) begin
      repeat (100) @(negedge clk);
      reg_read(4'hA, d);
    end
    reg_read(4'h0, d); check("R9 tx reached wm", d & 8'h02, 8'h02);

    // R9 RX watermark = 4, then R7 fill RX
    reg_write(4'hE, 8'h24);
    reg_write(4'h0, 8'h01);
    for (int i = 0; i < 3; i++) begin
      rx_q.push_back(8'(8'h10 + i)); send_serial(8'(8'h10 + i));
    end
    reg_read(4'h0, d); check("R9 rx below wm", d & 8'h01, 8'h00);
    rx_q.push_back(8'h13); send_serial(8'h13);
    reg_read(4'h0, d); check("R9 rx at wm", d & 8'h01, 8'h01);
    for (int i = 4; i < 33; i++) begin
      if (i < 32) rx_q.push_back(8'(8'h10 + i));
      send_serial(8'(8'h10 + i));
    end
    reg_read(4'hB, d); check("R7 rx count capped", d, 8'd32);
    reg_read(4'hD, d); check("R8 rx full", d & 8'h18, 8'h10);
    for (int i = 0; i < 32; i++) begin
      reg_read(4'hC, d); check("R5 R7 rx order", d, rx_q.pop_front());
    end
    reg_read(4'hC, d); check("R7 R6 dropped byte absent", d, 8'h00);

    // finish TX scoreboard
    repeat (12 * BIT) @(negedge clk);
    d = 8'hFF;
    while (d != 8'h00) begin
      repeat (200) @(negedge clk);
      reg_read(4'hA, d);
    end
    repeat (12 * BIT) @(negedge clk);
    check("R4 all frames sent", 8'(tx_q.size()), 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule